// File: doc/BRIEF.md
# Colored-Button Unlock Sequence Detector

This block watches a panel of one start button and three colored buttons (red, green and blue) and raises an unlock strobe when the operator presses start and then the four-press code red, blue, green, red. A separate summary line, `press_any`, is high in any cycle in which a colored button is pressed. A colored press counts only when that summary line is high.

Each step of the code advances only when the expected color is pressed with the other two colors low. Any other colored press sends the detector back to waiting for start. Cycles with no colored press leave the current step unchanged. The unlock output comes straight from a flip-flop, so it cannot glitch.

Every input is taken to be a clean press that lasts one clock cycle. Debouncing, timeouts and changing the code are left to other logic.

Top module: `code_lock_detector`

## Requirements
- R1: While reset is asserted, and until the first press after reset is released, `unlock` is 0 and the detector waits for start.
- R2: While waiting for start, colored presses have no effect. A cycle with `begin_btn`=1 arms the detector.
- R3: Once armed, or part way through the code, a cycle with `press_any`=0 keeps the current step. This holds even when color bits are high in that cycle.
- R4: A step advances only on a lone press of its expected color: `press_any`=1, the expected color bit 1 and the other two color bits 0. The expected colors are red, then blue, then green, then red.
- R5: Three kinds of press return the detector to waiting for start, and a new start is then needed: a wrong color, two or more colors at once (red with blue does not count as red), and `press_any`=1 with no color bit set.
- R6: `unlock` is a registered output. It goes to 1 in the cycle after the clock edge that samples the final correct red press, and it stays at 1 for exactly one cycle.
- R7: After the unlock cycle the detector waits for start again, whatever the inputs were during that cycle.
- R8: `begin_btn` has no effect once the detector is armed. It neither restarts nor disturbs the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| begin_btn | input | 1 | Start button press |
| press_any | input | 1 | High when any colored button is pressed |
| press_red | input | 1 | Red button press |
| press_green | input | 1 | Green button press |
| press_blue | input | 1 | Blue button press |
| unlock | output | 1 | One-cycle unlock strobe, driven from a register |

## Verification
The assertions assume that the color bits and `press_any` are synchronous to `clk`, and that each button press lasts a single cycle. Under that assumption a transition always reflects exactly one press decision. The stimulus changes inputs only on the falling clock edge and holds every press for one cycle. It also drives inconsistent combinations on purpose: color bits with `press_any` low, `press_any` with no color bit, and several colors at once. These show that the detector's decisions stay well defined in those cases.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_GOT_1 = 3'd2,
    ST_GOT_2 = 3'd3,
    ST_GOT_3 = 3'd4,
    ST_OPEN  = 3'd5
  } lock_state_e;

  typedef enum logic [2:0] {
    PR_NONE = 3'd0,
    PR_RED  = 3'd1,
    PR_GRN  = 3'd2,
    PR_BLU  = 3'd3,
    PR_BAD  = 3'd4
  } press_cls_e;

  localparam int unsigned RST_STAGES = 2;

endpackage

// File: rtl/lock_rst_sync.sv
module lock_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  // assert immediately, release after STAGES rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/lock_press_classifier.sv
module lock_press_classifier
  import code_lock_pkg::*;
(
  input  logic       any_i,
  input  logic       red_i,
  input  logic       grn_i,
  input  logic       blu_i,
  output press_cls_e cls_o
);

  always_comb begin
    if (!any_i)                     cls_o = PR_NONE;
    else if (red_i && !grn_i && !blu_i) cls_o = PR_RED;
    else if (grn_i && !red_i && !blu_i) cls_o = PR_GRN;
    else if (blu_i && !red_i && !grn_i) cls_o = PR_BLU;
    else                            cls_o = PR_BAD;
  end

  // a lone-color class must have exactly one color bit set (R4, R5)
  always_comb begin
    if (cls_o == PR_RED || cls_o == PR_GRN || cls_o == PR_BLU)
      p_lone_color_r4: assert ($countones({red_i, grn_i, blu_i}) == 1 && any_i);
  end

endmodule

// File: rtl/lock_step_fsm.sv
module lock_step_fsm
  import code_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       begin_i,
  input  press_cls_e cls_i,
  output logic       unlock_o
);

  lock_state_e state_q, state_d;
  logic        state_ld;
  logic        unlock_q;

  function automatic lock_state_e step_to(input press_cls_e got,
                                          input press_cls_e want,
                                          input lock_state_e here,
                                          input lock_state_e nxt);
    if (got == PR_NONE)   return here;
    else if (got == want) return nxt;
    else                  return ST_IDLE;
  endfunction

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (begin_i) state_d = ST_ARMED;
      ST_ARMED: state_d = step_to(cls_i, PR_RED, ST_ARMED, ST_GOT_1);
      ST_GOT_1: state_d = step_to(cls_i, PR_BLU, ST_GOT_1, ST_GOT_2);
      ST_GOT_2: state_d = step_to(cls_i, PR_GRN, ST_GOT_2, ST_GOT_3);
      ST_GOT_3: state_d = step_to(cls_i, PR_RED, ST_GOT_3, ST_OPEN);
      ST_OPEN:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign state_ld = (state_d != state_q);

  // state register with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE;
    else if (state_ld) state_q <= state_d;
  end

  // dedicated output flop, glitch-free strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlock_q <= 1'b0;
    else        unlock_q <= (state_d == ST_OPEN);
  end

  assign unlock_o = unlock_q;

  logic in_seq;
  assign in_seq = (state_q == ST_ARMED) || (state_q == ST_GOT_1) ||
                  (state_q == ST_GOT_2) || (state_q == ST_GOT_3);

  p_idle_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && begin_i) |=> (state_q == ST_ARMED));

  p_idle_stay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !begin_i) |=> (state_q == ST_IDLE));

  p_hold_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_seq && cls_i == PR_NONE) |=> $stable(state_q));

  p_bad_press_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_seq && cls_i == PR_BAD) |=> (state_q == ST_IDLE));

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_o |=> !unlock_o);

  p_strobe_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_o == (state_q == ST_OPEN));

  p_open_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPEN) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/code_lock_detector.sv
module code_lock_detector
  import code_lock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic begin_btn,
  input  logic press_any,
  input  logic press_red,
  input  logic press_green,
  input  logic press_blue,
  output logic unlock
);

  logic       rst_sync_n;
  press_cls_e cls;

  lock_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lock_press_classifier classify_i (
    .any_i (press_any),
    .red_i (press_red),
    .grn_i (press_green),
    .blu_i (press_blue),
    .cls_o (cls)
  );

  lock_step_fsm fsm_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .begin_i  (begin_btn),
    .cls_i    (cls),
    .unlock_o (unlock)
  );

  // reset holds the strobe low (R1)
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_sync_n |-> !unlock);

endmodule

// File: tb/code_lock_detector_tb_top.sv
module code_lock_detector_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  logic begin_btn, press_any, press_red, press_green, press_blue;
  logic unlock;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    logic  exp;
    string tag;
  } exp_item_t;

  exp_item_t sb_q[$];

  always #2 clk = ~clk;  // 250 MHz

  code_lock_detector dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .begin_btn   (begin_btn),
    .press_any   (press_any),
    .press_red   (press_red),
    .press_green (press_green),
    .press_blue  (press_blue),
    .unlock      (unlock)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: unlock=%b expected %b", tag, act, exp);
    end
  endtask

  // driver: one cycle of inputs, expected unlock after the consuming edge
  task automatic drive(input logic bg, input logic an, input logic rd,
                       input logic gr, input logic bl, input logic exp,
                       input string tag);
    exp_item_t it;
    @(negedge clk);
    begin_btn   = bg;
    press_any   = an;
    press_red   = rd;
    press_green = gr;
    press_blue  = bl;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic go(input logic exp, input string tag);  drive(1,0,0,0,0,exp,tag); endtask
  task automatic red(input logic exp, input string tag); drive(0,1,1,0,0,exp,tag); endtask
  task automatic blu(input logic exp, input string tag); drive(0,1,0,0,1,exp,tag); endtask
  task automatic grn(input logic exp, input string tag); drive(0,1,0,1,0,exp,tag); endtask
  task automatic nop(input logic exp, input string tag); drive(0,0,0,0,0,exp,tag); endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      check(unlock, it.exp, it.tag);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    begin_btn = 0; press_any = 0; press_red = 0; press_green = 0; press_blue = 0;
    repeat (3) @(negedge clk);
    check(unlock, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(unlock, 1'b0, "R1 after release");

    // R4 R6 basic code
    go(0,"R4 start"); red(0,"R4 red1"); blu(0,"R4 blue"); grn(0,"R4 green");
    red(1,"R6 final red opens"); nop(0,"R6 strobe one cycle");

    // R7: inputs during the open cycle are ignored
    go(0,"R4 start"); red(0,"R4 red1"); blu(0,"R4 blue"); grn(0,"R4 green");
    red(1,"R6 open");
    go(0,"R7 start during open ignored");
    red(0,"R7 idle"); blu(0,"R7 idle"); grn(0,"R7 idle"); red(0,"R7 no unlock");

    // R2: colors while waiting do nothing
    red(0,"R2 idle red"); blu(0,"R2 idle blue"); grn(0,"R2 idle green"); red(0,"R2 idle red");
    drive(0,1,1,1,1,0,"R2 idle all colors");

    // R3: quiet cycles and color bits without press_any hold the step
    go(0,"R3 start"); nop(0,"R3 hold"); drive(0,0,0,1,1,0,"R3 bits w/o any");
    red(0,"R3 red1"); nop(0,"R3 hold"); nop(0,"R3 hold");
    blu(0,"R3 blue"); drive(0,0,1,0,0,0,"R3 bits w/o any");
    grn(0,"R3 green"); nop(0,"R3 hold"); red(1,"R3 unlock after gaps");
    nop(0,"R6 strobe drop");

    // R5: red with blue is not red
    go(0,"R5 start"); drive(0,1,1,0,1,0,"R5 red+blue");
    red(0,"R5 idle"); blu(0,"R5 idle"); grn(0,"R5 idle"); red(0,"R5 needs restart");

    // R5: wrong color mid-code
    go(0,"R5 start"); red(0,"R5 red1"); blu(0,"R5 blue"); blu(0,"R5 wrong blue");
    grn(0,"R5 idle"); red(0,"R5 no unlock");

    // R5: press_any with no color bit
    go(0,"R5 start"); red(0,"R5 red1"); drive(0,1,0,0,0,0,"R5 empty press");
    blu(0,"R5 idle"); grn(0,"R5 idle"); red(0,"R5 no unlock");

    // R5: wrong last press
    go(0,"R5 start"); red(0,"R5 red1"); blu(0,"R5 blue"); grn(0,"R5 green");
    grn(0,"R5 wrong final"); nop(0,"R5 no unlock");

    // R8: start button ignored mid-sequence
    go(0,"R8 start"); go(0,"R8 second start"); red(0,"R8 red1");
    go(0,"R8 start mid"); blu(0,"R8 blue"); grn(0,"R8 green");
    red(1,"R8 unlock"); nop(0,"R8 strobe drop");

    // R4 back-to-back codes
    go(0,"R4 start"); red(0,"R4 red1"); blu(0,"R4 blue"); grn(0,"R4 green");
    red(1,"R4 first open"); go(0,"R7 start in open"); go(0,"R4 restart");
    red(0,"R4 red1"); blu(0,"R4 blue"); grn(0,"R4 green"); red(1,"R4 second open");
    nop(0,"R6 strobe drop");

    nop(0,"R1 tail"); nop(0,"R1 tail");
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule